// File: doc/BRIEF.md
# Pipelined Eight-Lane Transposition Sorter

This block sorts a group of eight unsigned words in hardware. The eight words enter together as one array. They pass through eight registered stages of compare-exchange cells. The stages alternate between two pairings: one pairs lanes starting at lane 0, the other pairs lanes starting at lane 1. Each cell registers both of its outputs, so every stage adds exactly one clock of latency. A fresh group may be presented on every clock cycle, and each sorted group leaves eight cycles after it entered.

Each group carries a valid flag that travels alongside it through the pipeline. The interface is a valid-only stream. The block never stalls and has no ready signal, so the consumer must accept every output group in the cycle it appears. The word width is a parameter.

Top module: `ote_sorter`

## Requirements
- R1: When `out_valid` is high, `out_data` is in ascending order: lane 0 holds the smallest word and lane 7 the largest, with lane i at or below lane i+1.
- R2: Each output group holds exactly the same multiset of words as the input group it came from, so no word is lost, duplicated or altered.
- R3: `out_valid` is high in the cycle that lies exactly eight clock edges after the edge that sampled `in_valid` high, and the matching sorted data appears in that same cycle.
- R4: Groups presented on consecutive cycles come out on consecutive cycles, in the order they entered, with no gaps between them.
- R5: Words are compared as unsigned numbers, so a word with its top bit set sorts above any word with its top bit clear.
- R6: Equal words are handled correctly, including groups where every word is the same.
- R7: A synchronous reset clears every valid bit in the pipeline, so `out_valid` is low after reset and stays low until a new valid group has travelled the whole pipeline.
- R8: A group presented while `in_valid` is low never raises `out_valid`.
- R9: The word width is the parameter `W`, which defaults to 8 bits. Lane i of each array port occupies element i of a packed array of `W`-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a group to be sorted this cycle |
| in_data | input | 8 x W | Eight unsigned input words, lane 0 to lane 7 |
| out_valid | output | 1 | Marks `out_data` as a sorted group |
| out_data | output | 8 x W | Sorted words; lane 0 is the smallest |

## Verification
The assertions assume that the cycles after reset are counted from the first edge at which reset is low. They also assume that data registers whose valid bit is clear may hold any value. For that reason, ordering and permutation are checked only where a valid bit accompanies the data. The stimulus keeps `in_valid` at a known level through reset. It drives inputs only between clock edges, so the delayed-valid comparison never sees an undefined history. The patterns cover reversed, already-sorted, all-equal, two-valued and top-bit-set groups, plus a burst of pseudo-random groups sent back to back.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  localparam int N_LANES  = 8;
  localparam int N_STAGES = 8;

  typedef enum logic {
    PAIR_EVEN = 1'b0,
    PAIR_ODD  = 1'b1
  } pairing_e;
endpackage

// File: rtl/cmpx_cell.sv
module cmpx_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  always_ff @(posedge clk) begin
    if (a > b) begin
      hi <= a;
      lo <= b;
    end else begin
      hi <= b;
      lo <= a;
    end
  end

  // R1
  cell_order_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> (hi >= lo));

  // R2
  cell_perm_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> ((hi == $past(a) && lo == $past(b)) ||
             (hi == $past(b) && lo == $past(a))));
endmodule

// File: rtl/ote_stage.sv
module ote_stage
  import sorter_pkg::*;
#(
  parameter int       W       = 8,
  parameter pairing_e PAIRING = PAIR_EVEN
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       vld_i,
  input  logic [N_LANES-1:0][W-1:0]  d_i,
  output logic                       vld_o,
  output logic [N_LANES-1:0][W-1:0]  d_o
);
  localparam int FIRST  = (PAIRING == PAIR_ODD) ? 1 : 0;
  localparam int NCELLS = (N_LANES - FIRST) / 2;
  localparam int LAST   = FIRST + 2 * NCELLS;

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  for (genvar k = 0; k < NCELLS; k++) begin : g_cell
    cmpx_cell #(.W(W)) u_cell (
      .clk (clk),
      .rst (rst),
      .vld (vld_i),
      .a   (d_i[FIRST + 2*k]),
      .b   (d_i[FIRST + 2*k + 1]),
      .hi  (d_o[FIRST + 2*k + 1]),
      .lo  (d_o[FIRST + 2*k])
    );
  end

  if (FIRST > 0) begin : g_pass_low
    always_ff @(posedge clk) d_o[0] <= d_i[0];
  end

  if (LAST < N_LANES) begin : g_pass_high
    always_ff @(posedge clk) d_o[N_LANES-1] <= d_i[N_LANES-1];
  end
endmodule

// File: rtl/ote_sorter.sv
module ote_sorter
  import sorter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [N_LANES-1:0][W-1:0] in_data,
  output logic                      out_valid,
  output logic [N_LANES-1:0][W-1:0] out_data
);
  logic [N_STAGES:0]                      v;
  logic [N_STAGES:0][N_LANES-1:0][W-1:0]  d;

  assign v[0] = in_valid;
  assign d[0] = in_data;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    ote_stage #(
      .W       (W),
      .PAIRING ((s % 2 == 1) ? PAIR_ODD : PAIR_EVEN)
    ) u_stage (
      .clk   (clk),
      .rst   (rst),
      .vld_i (v[s]),
      .d_i   (d[s]),
      .vld_o (v[s+1]),
      .d_o   (d[s+1])
    );
  end

  assign out_valid = v[N_STAGES];
  assign out_data  = d[N_STAGES];

  // Checker state: edges since reset, saturating at pipeline depth
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= 4'd0;
    else if (since_rst < 4'd8) since_rst <= since_rst + 4'd1;
  end

  for (genvar i = 0; i < N_LANES - 1; i++) begin : g_sorted
    // R1
    out_sorted_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data[i] <= out_data[i+1]));
  end

  // R3
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4'd8) |-> (out_valid == $past(in_valid, 8)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/ote_sorter_bench.sv
`timescale 1ns/1ps
module ote_sorter_bench;
  localparam int W  = 8;
  localparam int NT = 6;
  typedef logic [7:0][W-1:0] grp_t;

  // Table: element order in each pattern is lane 7 ... lane 0
  localparam grp_t VIN [NT] = '{
    '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7},
    '{8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
    '{8'd64, 8'd1, 8'd127, 8'd128, 8'd0, 8'd255, 8'd3, 8'd200},
    '{8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5},
    '{8'd2, 8'd9, 8'd2, 8'd9, 8'd2, 8'd9, 8'd2, 8'd9},
    '{8'd0, 8'd255, 8'd0, 8'd255, 8'd255, 8'd0, 8'd255, 8'd0}
  };
  localparam grp_t VEXP [NT] = '{
    '{8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
    '{8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
    '{8'd255, 8'd200, 8'd128, 8'd127, 8'd64, 8'd3, 8'd1, 8'd0},
    '{8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5},
    '{8'd9, 8'd9, 8'd9, 8'd9, 8'd2, 8'd2, 8'd2, 8'd2},
    '{8'd255, 8'd255, 8'd255, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  grp_t in_data = '0;
  logic out_valid;
  grp_t out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  grp_t stim [32];
  grp_t expv [32];

  always #2.5 clk = ~clk;

  ote_sorter #(.W(W)) u_ote_sorter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic grp_t ref_sort(grp_t g);
    grp_t r = g;
    for (int p = 0; p < 8; p++)
      for (int j = 0; j < 7; j++)
        if (r[j] > r[j+1]) begin
          logic [W-1:0] t = r[j];
          r[j] = r[j+1];
          r[j+1] = t;
        end
    return r;
  endfunction

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_valid=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_grp(string req, grp_t act, grp_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_data=%h expected %h", req, act, exp);
    end
  endtask

  // Feed n groups back to back; each is seen 8 negedges after it was driven (R3, R4)
  task automatic run_burst(int n, string req);
    for (int cyc = 0; cyc < n + 9; cyc++) begin
      @(negedge clk);
      if (cyc >= 8 && cyc - 8 < n) begin
        chk_bit({req, "/R3"}, out_valid, 1'b1);
        chk_grp({req, "/R1/R2/R4"}, out_data, expv[cyc-8]);
      end else begin
        chk_bit({req, "/R3"}, out_valid, 1'b0);
      end
      if (cyc < n) begin
        in_valid = 1'b1;
        in_data  = stim[cyc];
      end else begin
        in_valid = 1'b0;
        in_data  = '1;
      end
    end
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    chk_bit("R7 reset state", out_valid, 1'b0);

    // Table patterns: reversed, sorted, unsigned R5, equal R6, duplicates
    for (int i = 0; i < NT; i++) begin
      stim[i] = VIN[i];
      expv[i] = VEXP[i];
    end
    run_burst(NT, "R5/R6 table");

    // Pseudo-random burst, expected from a bench reference sort (R9 default width)
    for (int i = 0; i < 20; i++) begin
      for (int j = 0; j < 8; j++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        stim[i][j] = lfsr[W-1:0];
      end
      expv[i] = ref_sort(stim[i]);
    end
    run_burst(20, "R9 random");

    // R8: data with in_valid low never raises out_valid
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk_bit("R8 invalid input", out_valid, 1'b0);
      in_valid = 1'b0;
      in_data  = VIN[2];
    end

    // R7: reset in mid-flight clears all groups in the pipeline
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = VIN[c];
    end
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 10; c++) begin
      chk_bit("R7 reset flush", out_valid, 1'b0);
      @(negedge clk);
    end

    // Recovery after reset
    stim[0] = VIN[2];
    expv[0] = VEXP[2];
    run_burst(1, "R7 recovery");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule